// File: doc/BRIEF.md
# Phase Tracking Lock Detector

This block aligns two clock paths by choosing a setting for a tapped delay line. After reset it sweeps the delay upward from zero, one tap per clock, until the phase detector reports exactly the target phase code with the requested slope direction. It then switches to tracking. From then on it moves the delay by at most one tap per clock to follow drift between the paths, and it publishes a locked and a lost flag with asymmetric hysteresis.

When lock is lost, a policy input chooses the response. The block either keeps tracking from where it stands or returns to a fresh sweep from tap zero. A snapshot request copies the delay and the measured phase into holding registers, so that a slow reader sees a coherent pair. The phase detector and the delay line sit outside the block. Every clock is one evaluation: the phase inputs must reflect the delay currently driven.

Top module: `phase_lock_tracker`

## Requirements
- R1: After the synchronous active-high reset, `delay` is 0, `tracking` is 0, `locked` and `lost` are 0, and both snapshot outputs are 0.
- R2: While `tracking` is 0 and there is no match, `delay` rises by one each clock. From 432 it wraps to 0.
- R3: A match needs `meas_phase` equal to `tgt_phase` and `meas_fall` equal to `tgt_fall` (1 means a falling slope). On a match the next clock sets `tracking` and `locked`, clears `lost`, and leaves `delay` unchanged. An equal code with the wrong slope is not a match.
- R4: While tracking, the error is the absolute difference of the two 5-bit codes. A zero error leaves `delay` unchanged. Otherwise `delay` moves one tap per clock: up when the measured code is above target on a falling target slope or below target on a rising one, and down in the other two cases.
- R5: While tracking, an error above 4 clears `locked` and sets `lost` on the next clock.
- R6: While tracking, an error of 3 or less (and no range fault) sets `locked` and clears `lost`. An error of exactly 4 leaves both flags as they are.
- R7: `lost` is never set before lock has first been reached. A sweep that never matches keeps `lost` at 0.
- R8: While tracking, a step that would take `delay` below 0 or above 432 is not taken. It counts as loss of lock regardless of the error.
- R9: With `restart_on_loss` at 0, a loss leaves the block tracking. With it at 1, a loss returns the block to the sweep with `delay` 0. `lost` then stays set until the next match.
- R10: A clock with `snap_req` at 1 loads `snap_delay` with `delay` and `snap_phase` with `meas_phase`. Both hold their values while `snap_req` is 0.
- R11: `locked` and `lost` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one evaluation per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| meas_phase | input | 5 | Phase code reported for the current delay |
| meas_fall | input | 1 | Slope of the reported phase, 1 = falling |
| tgt_phase | input | 5 | Desired phase code |
| tgt_fall | input | 1 | Desired slope, 1 = falling |
| restart_on_loss | input | 1 | 1 = restart the sweep on loss, 0 = keep tracking |
| snap_req | input | 1 | Capture delay and phase this clock |
| delay | output | 9 | Delay-line tap in use |
| tracking | output | 1 | 1 in tracking mode, 0 while sweeping |
| locked | output | 1 | Lock indication with hysteresis |
| lost | output | 1 | Set on loss after lock was reached |
| snap_delay | output | 9 | Captured delay |
| snap_phase | output | 5 | Captured phase code |

## Verification
The hardest condition to reach from the ports is a range fault while tracking. The error is small at that moment, so the fault must drop lock by itself, without help from the error threshold. The bench models the detector as a triangle-shaped phase curve over the delay, offset by a drift term. It picks an offset that makes the match fall at tap 2. It then drifts the curve one step per clock, so that tracking walks the delay down to 0 and then asks for one more step downward. A second hard case is the error of exactly 4 that must hold the flags. It comes from a single five-step jump in the drift term, after which tracking walks back through errors of 4 and 3.

// File: rtl/phase_lock_tracker.sv
module phase_lock_tracker #(
  parameter int DLY_W       = 9,
  parameter int PH_W        = 5,
  parameter int DLY_MAX     = 432,
  parameter int LOSE_ABOVE  = 4,
  parameter int LOCK_WITHIN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  meas_phase,
  input  logic             meas_fall,
  input  logic [PH_W-1:0]  tgt_phase,
  input  logic             tgt_fall,
  input  logic             restart_on_loss,
  input  logic             snap_req,
  output logic [DLY_W-1:0] delay,
  output logic             tracking,
  output logic             locked,
  output logic             lost,
  output logic [DLY_W-1:0] snap_delay,
  output logic [PH_W-1:0]  snap_phase
);

  localparam logic [DLY_W-1:0] TOP  = DLY_W'(DLY_MAX);
  localparam logic [DLY_W-1:0] ONE  = DLY_W'(1);
  localparam logic [PH_W-1:0]  LOSE = PH_W'(LOSE_ABOVE);
  localparam logic [PH_W-1:0]  KEEP = PH_W'(LOCK_WITHIN);

  logic            ahead, hit, go_up, go_dn, at_edge, far, near;
  logic [PH_W-1:0] err;

  assign ahead   = meas_phase > tgt_phase;
  assign err     = ahead ? meas_phase - tgt_phase : tgt_phase - meas_phase;
  assign hit     = (err == '0) && (meas_fall == tgt_fall);
  assign go_up   = (err != '0) && (ahead == tgt_fall);
  assign go_dn   = (err != '0) && (ahead != tgt_fall);
  assign at_edge = (go_up && delay == TOP) || (go_dn && delay == '0);
  assign far     = (err > LOSE) || at_edge;
  assign near    = (err <= KEEP) && !at_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      delay    <= '0;
      tracking <= 1'b0;
      locked   <= 1'b0;
      lost     <= 1'b0;
    end else if (!tracking) begin
      if (hit) begin
        tracking <= 1'b1;
        locked   <= 1'b1;
        lost     <= 1'b0;
      end else begin
        delay <= (delay == TOP) ? '0 : delay + ONE;
      end
    end else begin
      if (far) begin
        locked <= 1'b0;
        lost   <= 1'b1;
      end else if (near) begin
        locked <= 1'b1;
        lost   <= 1'b0;
      end
      if (far && restart_on_loss) begin
        tracking <= 1'b0;
        delay    <= '0;
      end else if (!at_edge) begin
        if (go_up)      delay <= delay + ONE;
        else if (go_dn) delay <= delay - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_delay <= '0;
      snap_phase <= '0;
    end else if (snap_req) begin
      snap_delay <= delay;
      snap_phase <= meas_phase;
    end
  end

endmodule

// File: rtl/phase_lock_tracker_chk.sv
module phase_lock_tracker_chk #(
  parameter int DLY_W   = 9,
  parameter int PH_W    = 5,
  parameter int DLY_MAX = 432
) (
  input logic             clk,
  input logic             rst,
  input logic [PH_W-1:0]  meas_phase,
  input logic             meas_fall,
  input logic [PH_W-1:0]  tgt_phase,
  input logic             tgt_fall,
  input logic             snap_req,
  input logic [DLY_W-1:0] delay,
  input logic             tracking,
  input logic             locked,
  input logic             lost,
  input logic [DLY_W-1:0] snap_delay,
  input logic [PH_W-1:0]  snap_phase
);

  logic match;
  assign match = (meas_phase == tgt_phase) && (meas_fall == tgt_fall);

  assert_sweep_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!tracking && !match && delay != DLY_W'(DLY_MAX)) |=> delay == $past(delay) + DLY_W'(1));

  assert_sweep_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (!tracking && !match && delay == DLY_W'(DLY_MAX)) |=> delay == '0);

  assert_locked_only_tracking_R3: assert property (@(posedge clk) disable iff (rst)
    locked |-> tracking);

  assert_single_tap_R4: assert property (@(posedge clk) disable iff (rst)
    tracking |=> (!tracking || delay == $past(delay) ||
                  delay == $past(delay) + DLY_W'(1) || delay + DLY_W'(1) == $past(delay)));

  assert_lost_after_lock_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> $past(tracking));

  assert_delay_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    delay <= DLY_W'(DLY_MAX));

  assert_snapshot_R10: assert property (@(posedge clk) disable iff (rst)
    snap_req |=> (snap_delay == $past(delay) && snap_phase == $past(meas_phase)));

  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(locked && lost));

endmodule

bind phase_lock_tracker phase_lock_tracker_chk #(
  .DLY_W(DLY_W), .PH_W(PH_W), .DLY_MAX(DLY_MAX)
) u_chk (
  .clk(clk), .rst(rst), .meas_phase(meas_phase), .meas_fall(meas_fall),
  .tgt_phase(tgt_phase), .tgt_fall(tgt_fall), .snap_req(snap_req),
  .delay(delay), .tracking(tracking), .locked(locked), .lost(lost),
  .snap_delay(snap_delay), .snap_phase(snap_phase)
);

// File: tb/phase_lock_tracker_test.sv
module phase_lock_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] meas_phase = '0;
  logic       meas_fall = 1'b0;
  logic [4:0] tgt_phase = 5'd6;
  logic       tgt_fall = 1'b1;
  logic       restart_on_loss = 1'b0;
  logic       snap_req = 1'b0;
  logic [8:0] delay, snap_delay;
  logic       tracking, locked, lost;
  logic [4:0] snap_phase;

  phase_lock_tracker uut (
    .clk(clk), .rst(rst), .meas_phase(meas_phase), .meas_fall(meas_fall),
    .tgt_phase(tgt_phase), .tgt_fall(tgt_fall), .restart_on_loss(restart_on_loss),
    .snap_req(snap_req), .delay(delay), .tracking(tracking), .locked(locked),
    .lost(lost), .snap_delay(snap_delay), .snap_phase(snap_phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string      tag;
    bit         is_snap;
    logic [8:0] dly;
    logic       trk, lk, ls;
    logic [4:0] ph;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  int   off = 0;
  bit   dead = 1'b0;
  bit   done = 1'b0;

  task automatic drive_phase();
    int raw;
    if (dead) begin
      meas_phase = 5'd0;
      meas_fall  = 1'b0;
    end else begin
      raw = (int'(delay) + off) % 64;
      meas_phase = (raw < 32) ? 5'(raw) : 5'(63 - raw);
      meas_fall  = (raw >= 32);
    end
  endtask

  task automatic edge_step();
    @(negedge clk);
    drive_phase();
  endtask

  task automatic expect_state(string tag, logic [8:0] d, logic t, logic k, logic s);
    exp_t e;
    e.tag = tag; e.is_snap = 1'b0; e.dly = d; e.trk = t; e.lk = k; e.ls = s; e.ph = '0;
    exp_q.push_back(e);
  endtask

  task automatic expect_snap(string tag, logic [8:0] d, logic [4:0] p);
    exp_t e;
    e.tag = tag; e.is_snap = 1'b1; e.dly = d; e.ph = p; e.trk = 0; e.lk = 0; e.ls = 0;
    exp_q.push_back(e);
  endtask

  task automatic compare(exp_t e);
    n_run++;
    if (e.is_snap) begin
      if (snap_delay !== e.dly || snap_phase !== e.ph) begin
        n_fail++;
        $display("FAIL %s: snap got %0d/%0d expected %0d/%0d", e.tag,
                 snap_delay, snap_phase, e.dly, e.ph);
      end
    end else if (delay !== e.dly || tracking !== e.trk || locked !== e.lk || lost !== e.ls) begin
      n_fail++;
      $display("FAIL %s: got dly=%0d trk=%0b lk=%0b ls=%0b expected dly=%0d trk=%0b lk=%0b ls=%0b",
               e.tag, delay, tracking, locked, lost, e.dly, e.trk, e.lk, e.ls);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive_phase();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R1 reset state and R2/R7 sweep with a detector that never matches
    dead = 1'b1;
    snap_req = 1'b1;
    do_reset();
    n_run++;
    if (delay !== 9'd0 || tracking !== 1'b0 || locked !== 1'b0 || lost !== 1'b0 ||
        snap_delay !== 9'd0 || snap_phase !== 5'd0) begin
      n_fail++;
      $display("FAIL R1: got dly=%0d trk=%0b lk=%0b ls=%0b snap=%0d/%0d expected all zero",
               delay, tracking, locked, lost, snap_delay, snap_phase);
    end
    snap_req = 1'b0;
    repeat (4) edge_step();
    expect_state("R2", 9'd5, 0, 0, 0);
    edge_step();
    repeat (426) edge_step();
    expect_state("R7", 9'd432, 0, 0, 0);
    edge_step();
    expect_state("R2 wrap", 9'd0, 0, 0, 0);
    edge_step();

    // Sweep to a match at tap 57 (code 6 falling); tap 6 gives code 6 rising
    dead = 1'b0; off = 0; restart_on_loss = 1'b0;
    do_reset();
    repeat (6) edge_step();
    expect_state("R3 slope mismatch", 9'd7, 0, 0, 0);
    edge_step();
    repeat (49) edge_step();
    expect_state("R2", 9'd57, 0, 0, 0);
    edge_step();
    expect_state("R3", 9'd57, 1, 1, 0);
    edge_step();

    snap_req = 1'b1;
    expect_snap("R10 capture", 9'd57, 5'd6);
    edge_step();
    snap_req = 1'b0;
    off = 1; drive_phase();
    expect_state("R4 step down", 9'd56, 1, 1, 0);
    expect_snap("R10 hold", 9'd57, 5'd6);
    edge_step();
    expect_state("R4 zero error", 9'd56, 1, 1, 0);
    edge_step();

    off = 6; drive_phase();
    expect_state("R5 R9 keep tracking", 9'd55, 1, 0, 1);
    edge_step();
    expect_state("R6 error four holds", 9'd54, 1, 0, 1);
    edge_step();
    expect_state("R6 relock", 9'd53, 1, 1, 0);
    edge_step();
    repeat (2) edge_step();
    expect_state("R4 settled", 9'd51, 1, 1, 0);
    edge_step();

    restart_on_loss = 1'b1;
    off = 14; drive_phase();
    expect_state("R9 restart", 9'd0, 0, 0, 1);
    edge_step();
    repeat (42) edge_step();
    expect_state("R9 lost held in sweep", 9'd43, 0, 0, 1);
    edge_step();
    expect_state("R9 relock", 9'd43, 1, 1, 0);
    edge_step();

    // R8: drift pushes tracking below tap 0
    restart_on_loss = 1'b0;
    off = 55;
    do_reset();
    repeat (2) edge_step();
    expect_state("R3 low tap", 9'd2, 1, 1, 0);
    edge_step();
    off = 56; drive_phase();
    expect_state("R4", 9'd1, 1, 1, 0);
    edge_step();
    off = 57; drive_phase();
    expect_state("R4", 9'd0, 1, 1, 0);
    edge_step();
    off = 58; drive_phase();
    expect_state("R8 range fault", 9'd0, 1, 0, 1);
    edge_step();
    expect_state("R8 fault persists", 9'd0, 1, 0, 1);
    edge_step();
    off = 57; drive_phase();
    expect_state("R8 R6 recover", 9'd0, 1, 1, 0);
    edge_step();
    edge_step();

    finish_run();
  end
endmodule